// File: doc/BRIEF.md
# Per-Bank Command-Pair Pattern Counters

This block observes the column accesses a memory controller sends to a set of DRAM banks and sorts each access into a pattern bin. A row-buffer hit is binned by the type of the bank's previous column command together with the type of the current one. A row-buffer miss is binned by what the bank did before its row was closed. The options are a write, a run of exactly x reads since the row was opened (x from 1 up to a configured limit m), or anything else. Every access also adds one to its bank's request count.

The resulting histograms describe a workload's access stream in terms of command pairs. A software model can weight these counts with DRAM timing values. The bank with the most requests is reported all the time, so that one bank's statistics can stand for the whole workload. The counters are read one word at a time through an addressed port.

The limit m is normally (tRAS - tRCD - tRTP) / tCCD for the timing set in use. Typical values are 2 to 4. The limit is supplied at run time and capped at the number of run bins that were built.

Top module: `cmdpair_stats`

## Requirements
- R1: An access changes only the counters and history of the bank named on `acc_bank`; the other banks' counters read back unchanged.
- R2: A hit (`acc_hit`=1) to a bank that has a previous column command adds one to a hit slot: 0 = write after write, 1 = write after read, 2 = read after write, 3 = read after read (`acc_write`=1 means write).
- R3: A miss whose bank saw exactly x reads and no write since its last miss (or since reset/clear), with 1 <= x <= min(`cfg_bins`, 4), adds one to slot 4+x (slots 5..8).
- R4: A miss whose bank's previous column command was a write adds one to slot 4.
- R5: Every other miss adds one to slot 9. This covers a bank with no history, a read run that followed a write, a run longer than the limit, and a limit of 0.
- R6: Every access adds one to its bank's slot 10 (request count). A hit to a bank with no history adds to nothing else.
- R7: `top_bank` gives the bank with the largest request count, with the lowest index winning a tie. It reflects the counts as they stood before the most recent clock edge.
- R8: Counters saturate at all-ones and do not wrap.
- R9: `clr` zeroes all counters and all bank history. When `clr` and `acc_valid` arrive in the same cycle, the access is dropped.
- R10: `rd_addr` is {bank, slot}, with the slot in the low 4 bits. `rd_data` shows the addressed counter one cycle later, with the value it held before that edge. Slots 11..15 read as zero.
- R11: Synchronous reset zeroes all counters, all history, `rd_data` and `top_bank`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of counters and history |
| acc_valid | input | 1 | Column access strobe |
| acc_bank | input | 3 | Bank of the access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_hit | input | 1 | 1 = row-buffer hit, 0 = miss |
| cfg_bins | input | 3 | Read-run bin limit m (capped at 4) |
| rd_addr | input | 7 | Counter address {bank, slot} |
| rd_data | output | CNT_W (32) | Counter value, one cycle after `rd_addr` |
| top_bank | output | 3 | Bank with the most requests |

## Verification
The counter that an access changes is updated at the edge that samples the strobe. Because `rd_data` is registered, a read issued at that same edge still returns the old value, and the new value appears only on a read issued one edge later. `top_bank` likewise trails the counts by one edge. The bench's reference model therefore takes its expected read value and expected leader from its own state before applying the current access. It compares both outputs on the falling edge that follows. The read address sweeps every bank and slot, so all bins, the unused slots, saturation and clear are compared each cycle.

// File: rtl/cmdpair_pkg.sv
package cmdpair_pkg;
  typedef enum logic [1:0] {
    CK_NONE  = 2'd0,
    CK_READ  = 2'd1,
    CK_WRITE = 2'd2
  } cmd_kind_e;

  localparam int SLOT_WW    = 0;
  localparam int SLOT_RW    = 1;
  localparam int SLOT_WR    = 2;
  localparam int SLOT_RR    = 3;
  localparam int SLOT_WMISS = 4;
endpackage

// File: rtl/cmdpair_bank_track.sv
module cmdpair_bank_track
  import cmdpair_pkg::*;
#(
  parameter int RUN_W    = 3,
  parameter int MAX_BINS = 4,
  parameter int SLOT_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic              acc_write,
  input  logic              acc_hit,
  input  logic [RUN_W-1:0]  meff,
  output logic              bump,
  output logic [SLOT_W-1:0] bump_slot
);
  localparam logic [RUN_W-1:0]  RUN_MAX = '1;
  localparam logic [SLOT_W-1:0] OTHER   = SLOT_W'(SLOT_WMISS + MAX_BINS + 1);

  cmd_kind_e        last_q;
  logic             tainted_q;
  logic [RUN_W-1:0] run_q;

  always_comb begin
    bump      = 1'b0;
    bump_slot = OTHER;
    if (en) begin
      if (acc_hit) begin
        if (last_q != CK_NONE) begin
          bump = 1'b1;
          case ({last_q == CK_WRITE, acc_write})
            2'b11:   bump_slot = SLOT_W'(SLOT_WW);
            2'b01:   bump_slot = SLOT_W'(SLOT_RW);
            2'b10:   bump_slot = SLOT_W'(SLOT_WR);
            default: bump_slot = SLOT_W'(SLOT_RR);
          endcase
        end
      end else begin
        bump = 1'b1;
        if (last_q == CK_WRITE)
          bump_slot = SLOT_W'(SLOT_WMISS);
        else if (last_q == CK_READ && !tainted_q && run_q != '0 && run_q <= meff)
          bump_slot = SLOT_W'(SLOT_WMISS) + SLOT_W'(run_q);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      last_q    <= CK_NONE;
      tainted_q <= 1'b0;
      run_q     <= '0;
    end else if (en) begin
      last_q <= acc_write ? CK_WRITE : CK_READ;
      if (!acc_hit) begin
        tainted_q <= acc_write;
        run_q     <= acc_write ? '0 : RUN_W'(1);
      end else if (acc_write) begin
        tainted_q <= 1'b1;
      end else if (!tainted_q && run_q != RUN_MAX) begin
        run_q <= run_q + RUN_W'(1);
      end
    end
  end

  AST_MISS_RESTARTS_RUN: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && !acc_hit && !acc_write) |=> (run_q == RUN_W'(1) && !tainted_q)); // R3

  AST_BUMP_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (rst)
    bump |-> en); // R1
endmodule

// File: rtl/cmdpair_cnt_bank.sv
module cmdpair_cnt_bank #(
  parameter int CNT_W     = 32,
  parameter int NUM_SLOTS = 11,
  parameter int SLOT_W    = 4,
  parameter int REQ_SLOT  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic              bump,
  input  logic [SLOT_W-1:0] bump_slot,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [CNT_W-1:0]  rd_val,
  output logic [CNT_W-1:0]  req_val
);
  logic [CNT_W-1:0] cnt_q [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic inc;
    assign inc = en && ((s == REQ_SLOT) || (bump && bump_slot == SLOT_W'(s)));

    always_ff @(posedge clk) begin
      if (rst || clr)
        cnt_q[s] <= '0;
      else if (inc && cnt_q[s] != '1)
        cnt_q[s] <= cnt_q[s] + CNT_W'(1);
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (cnt_q[s] == '1 && !clr) |=> cnt_q[s] == '1); // R8

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
      clr |=> cnt_q[s] == '0); // R9
  end

  always_comb begin
    rd_val = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (rd_slot == SLOT_W'(s)) rd_val = cnt_q[s];
  end

  assign req_val = cnt_q[REQ_SLOT];
endmodule

// File: rtl/cmdpair_leader.sv
module cmdpair_leader #(
  parameter int NUM_BANKS = 8,
  parameter int CNT_W     = 32,
  parameter int BANK_W    = 3
) (
  input  logic [NUM_BANKS*CNT_W-1:0] req_flat,
  output logic [BANK_W-1:0]          lead
);
  logic [CNT_W-1:0] best_val;

  always_comb begin
    lead     = '0;
    best_val = req_flat[CNT_W-1:0];
    for (int b = 1; b < NUM_BANKS; b++) begin
      if (req_flat[b*CNT_W +: CNT_W] > best_val) begin
        best_val = req_flat[b*CNT_W +: CNT_W];
        lead     = BANK_W'(b);
      end
    end
  end
endmodule

// File: rtl/cmdpair_stats.sv
module cmdpair_stats #(
  parameter int NUM_BANKS = 8,
  parameter int CNT_W     = 32,
  parameter int MAX_BINS  = 4,
  parameter int RUN_W     = 3,
  parameter int CFG_W     = 3
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   clr,
  input  logic                                   acc_valid,
  input  logic [$clog2(NUM_BANKS)-1:0]           acc_bank,
  input  logic                                   acc_write,
  input  logic                                   acc_hit,
  input  logic [CFG_W-1:0]                       cfg_bins,
  input  logic [$clog2(NUM_BANKS)+$clog2(MAX_BINS+7)-1:0] rd_addr,
  output logic [CNT_W-1:0]                       rd_data,
  output logic [$clog2(NUM_BANKS)-1:0]           top_bank
);
  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int NUM_SLOTS = MAX_BINS + 7;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int REQ_SLOT  = NUM_SLOTS - 1;
  localparam int ADDR_W    = BANK_W + SLOT_W;

  logic [RUN_W-1:0]           meff;
  logic [NUM_BANKS-1:0]       bank_en;
  logic [NUM_BANKS-1:0]       bump_vec;
  logic [CNT_W-1:0]           rd_vals [NUM_BANKS];
  logic [NUM_BANKS*CNT_W-1:0] req_flat;
  logic [BANK_W-1:0]          lead;
  logic [BANK_W-1:0]          rd_bank;
  logic [SLOT_W-1:0]          rd_slot;

  assign meff    = (cfg_bins > CFG_W'(MAX_BINS)) ? RUN_W'(MAX_BINS) : RUN_W'(cfg_bins);
  assign rd_bank = rd_addr[ADDR_W-1:SLOT_W];
  assign rd_slot = rd_addr[SLOT_W-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [SLOT_W-1:0] bump_slot;

    assign bank_en[b] = acc_valid && !clr && acc_bank == BANK_W'(b);

    cmdpair_bank_track #(
      .RUN_W(RUN_W), .MAX_BINS(MAX_BINS), .SLOT_W(SLOT_W)
    ) u_track (
      .clk(clk), .rst(rst), .clr(clr), .en(bank_en[b]),
      .acc_write(acc_write), .acc_hit(acc_hit), .meff(meff),
      .bump(bump_vec[b]), .bump_slot(bump_slot)
    );

    cmdpair_cnt_bank #(
      .CNT_W(CNT_W), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .REQ_SLOT(REQ_SLOT)
    ) u_cnt (
      .clk(clk), .rst(rst), .clr(clr), .en(bank_en[b]),
      .bump(bump_vec[b]), .bump_slot(bump_slot), .rd_slot(rd_slot),
      .rd_val(rd_vals[b]), .req_val(req_flat[b*CNT_W +: CNT_W])
    );
  end

  cmdpair_leader #(
    .NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W), .BANK_W(BANK_W)
  ) u_leader (
    .req_flat(req_flat), .lead(lead)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      top_bank <= '0;
    end else begin
      rd_data  <= rd_vals[rd_bank];
      top_bank <= lead;
    end
  end

  AST_ONE_BANK_BUMP: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bump_vec)); // R1

  AST_CLEAR_DROPS_ACCESS: assert property (@(posedge clk) disable iff (rst)
    clr |-> bank_en == '0); // R9
endmodule

// File: tb/cmdpair_stats_bench.sv
module cmdpair_stats_bench;
  localparam int CW    = 6;
  localparam int MAXV  = (1 << CW) - 1;
  localparam int NCYC  = 24000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clr = 1'b0;
  logic          acc_valid = 1'b0;
  logic [2:0]    acc_bank = '0;
  logic          acc_write = 1'b0;
  logic          acc_hit = 1'b0;
  logic [2:0]    cfg_bins = 3'd2;
  logic [6:0]    rd_addr = '0;
  logic [CW-1:0] rd_data;
  logic [2:0]    top_bank;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int m_cnt [8][16];
  int m_last [8];
  bit m_taint [8];
  int m_run [8];

  always #10 clk = ~clk;

  cmdpair_stats #(.CNT_W(CW)) u_cmdpair_stats (
    .clk(clk), .rst(rst), .clr(clr), .acc_valid(acc_valid), .acc_bank(acc_bank),
    .acc_write(acc_write), .acc_hit(acc_hit), .cfg_bins(cfg_bins),
    .rd_addr(rd_addr), .rd_data(rd_data), .top_bank(top_bank)
  );

  function automatic string req_of(int slot);
    if (slot < 4)       return "R2";
    else if (slot == 4) return "R4";
    else if (slot < 9)  return "R3";
    else if (slot == 9) return "R5";
    else if (slot == 10) return "R6";
    else                return "R10";
  endfunction

  task automatic model_clear();
    for (int b = 0; b < 8; b++) begin
      for (int s = 0; s < 16; s++) m_cnt[b][s] = 0;
      m_last[b] = 0; m_taint[b] = 1'b0; m_run[b] = 0;
    end
  endtask

  task automatic bump(int b, int s);
    if (m_cnt[b][s] < MAXV) m_cnt[b][s]++;
  endtask

  function automatic int model_top();
    int best = 0;
    for (int b = 1; b < 8; b++)
      if (m_cnt[b][10] > m_cnt[best][10]) best = b;
    return best;
  endfunction

  task automatic model_access(int b, bit w, bit h, int cfg);
    int meff = (cfg > 4) ? 4 : cfg;
    bump(b, 10);
    if (h) begin
      if (m_last[b] != 0)
        bump(b, (m_last[b] == 2) ? (w ? 0 : 2) : (w ? 1 : 3));
      if (w) m_taint[b] = 1'b1;
      else if (!m_taint[b] && m_run[b] < 7) m_run[b]++;
    end else begin
      if (m_last[b] == 2) bump(b, 4);
      else if (m_last[b] == 1 && !m_taint[b] && m_run[b] >= 1 && m_run[b] <= meff)
        bump(b, 4 + m_run[b]);
      else bump(b, 9);
      m_taint[b] = w;
      m_run[b]   = w ? 0 : 1;
    end
    m_last[b] = w ? 2 : 1;
  endtask

  task automatic check(string req, int got, int exp, string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (NCYC + 1000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int exp_rd, exp_top, exp_slot;
    int cfg_list [8] = '{2, 3, 3, 4, 1, 0, 7, 4};
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11", int'(rd_data), 0, "rd_data in reset");
    check("R11", int'(top_bank), 0, "top_bank in reset");
    rst = 1'b0;
    exp_rd = 0; exp_top = 0; exp_slot = 0;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      if (cyc > 0) begin
        check(req_of(exp_slot), int'(rd_data), exp_rd, "rd_data");
        check("R7", int'(top_bank), exp_top, "top_bank");
      end
      if (cyc % 3000 == 0) cfg_bins = 3'(cfg_list[(cyc / 3000) % 8]);
      clr       = (cyc % 5000 == 2500) || (cyc % 7919 == 7000);
      acc_valid = ($urandom_range(0, 9) < 7);
      acc_bank  = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : 3'($urandom_range(0, 2));
      acc_write = ($urandom_range(0, 99) < 35);
      acc_hit   = ($urandom_range(0, 99) < 60);
      rd_addr   = 7'(cyc % 128);
      exp_slot  = cyc % 16;
      exp_rd    = m_cnt[(cyc % 128) / 16][exp_slot];
      exp_top   = model_top();
      if (clr) model_clear();
      else if (acc_valid) model_access(int'(acc_bank), acc_write, acc_hit, int'(cfg_bins));
    end
    @(negedge clk);
    check(req_of(exp_slot), int'(rd_data), exp_rd, "rd_data final");
    check("R7", int'(top_bank), exp_top, "top_bank final");
    finish_run();
  end
endmodule